// File: doc/BRIEF.md
# Five-Move Hand Game Judge

This block settles a single round of the five-move hand game (Rock, Paper, Scissors, Lizard, Spock) between two players. Each player's move arrives as a 3-bit code, and three outcome flags report whether player one won, player two won, or the round is a draw. The block is purely combinational: the flags follow the two codes directly, with no clock and no stored state.

Internally, a decode stage turns each code into a one-hot position on a five-slot ring and marks whether both codes are legal. Every move on that ring beats the two moves just below it. An outcome stage rotates one player's ring position to find the set of moves it beats, then intersects that set with the other player's position. Any illegal code on either side forces all three flags low. The logic is written as continuous assignments over dataflow operators, so changing the encoding only means editing one decode function.

Top module: `handGameJudge`

## Requirements
- R1: Move codes are Rock = 3'b000, Paper = 3'b001, Scissors = 3'b010, Lizard = 3'b011 and Spock = 3'b100. The codes 3'b101, 3'b110 and 3'b111 are illegal.
- R2: The win relation covers ten ordered pairs. Rock beats Scissors and Lizard. Paper beats Rock and Spock. Scissors beats Paper and Lizard. Lizard beats Paper and Spock. Spock beats Rock and Scissors.
- R3: `p1Wins` is 1 exactly when both codes are legal and player one's move beats player two's move under R2. Otherwise it is 0.
- R4: `p2Wins` is 1 exactly when both codes are legal and player two's move beats player one's move under R2. Otherwise it is 0.
- R5: When both players present the same legal code, `tied` is 1 and both win flags are 0.
- R6: When either code is illegal, all three outputs are 0, including the case where both codes are illegal.
- R7: For every pair of legal codes, exactly one of `p1Wins`, `p2Wins` and `tied` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| player1Move | input | 3 | Player one's move code |
| player2Move | input | 3 | Player two's move code |
| p1Wins | output | 1 | High when player one wins the round |
| p2Wins | output | 1 | High when player two wins the round |
| tied | output | 1 | High when both players show the same legal move |

## Verification
The hardest behaviour to confirm from the ports is the legality gate. It matters most when one code is legal and the other sits in the unused range, because a ring position built from a partly decoded code could still raise a flag. To reach this, the stimulus pairs each of the three illegal codes with every legal code, in both orders and also against another illegal code. After that, a full sweep of all 64 code pairs compares each flag against a reference table written directly from the ten winning pairs.

// File: rtl/handGamePkg.sv
package handGamePkg;

  localparam int MOVE_W    = 3;
  localparam int NUM_MOVES = 5;
  localparam int REACH     = (NUM_MOVES - 1) / 2;

  localparam logic [MOVE_W-1:0] CODE_ROCK     = 3'b000;
  localparam logic [MOVE_W-1:0] CODE_PAPER    = 3'b001;
  localparam logic [MOVE_W-1:0] CODE_SCISSORS = 3'b010;
  localparam logic [MOVE_W-1:0] CODE_LIZARD   = 3'b011;
  localparam logic [MOVE_W-1:0] CODE_SPOCK    = 3'b100;

  typedef logic [NUM_MOVES-1:0] ringHot_t;

  // Strobes handed from the decode stage to the outcome stage.
  typedef struct packed {
    logic     bothLegal;
    ringHot_t p1Ring;
    ringHot_t p2Ring;
  } judgeStrobes_t;

  // Ring order: each slot beats the REACH slots just below it (mod NUM_MOVES).
  // Rock=0, Spock=1, Paper=2, Lizard=3, Scissors=4.
  function automatic ringHot_t codeToRing(input logic [MOVE_W-1:0] code);
    case (code)
      CODE_ROCK:     return ringHot_t'(1) << 0;
      CODE_SPOCK:    return ringHot_t'(1) << 1;
      CODE_PAPER:    return ringHot_t'(1) << 2;
      CODE_LIZARD:   return ringHot_t'(1) << 3;
      CODE_SCISSORS: return ringHot_t'(1) << 4;
      default:       return '0;
    endcase
  endfunction

  // Rotate toward lower slots by k: result bit j = ring bit (j+k) mod N.
  function automatic ringHot_t rotDown(input ringHot_t ring, input int k);
    logic [2*NUM_MOVES-1:0] doubled;
    doubled = {ring, ring} >> k;
    return doubled[NUM_MOVES-1:0];
  endfunction

endpackage

// File: rtl/moveDecode.sv
module moveDecode
  import handGamePkg::*;
(
  input  logic [MOVE_W-1:0] p1Code,
  input  logic [MOVE_W-1:0] p2Code,
  output judgeStrobes_t     strobes
);

  ringHot_t p1Ring;
  ringHot_t p2Ring;

  assign p1Ring = codeToRing(p1Code);
  assign p2Ring = codeToRing(p2Code);

  assign strobes = '{bothLegal: (|p1Ring) & (|p2Ring),
                     p1Ring:    p1Ring,
                     p2Ring:    p2Ring};

endmodule

// File: rtl/outcomeDatapath.sv
module outcomeDatapath
  import handGamePkg::*;
(
  input  judgeStrobes_t strobes,
  output logic          p1Wins,
  output logic          p2Wins,
  output logic          tied
);

  ringHot_t p1PreyAcc [REACH+1];
  ringHot_t p2PreyAcc [REACH+1];

  assign p1PreyAcc[0] = '0;
  assign p2PreyAcc[0] = '0;

  for (genvar k = 1; k <= REACH; k++) begin : g_reach
    assign p1PreyAcc[k] = p1PreyAcc[k-1] | rotDown(strobes.p1Ring, k);
    assign p2PreyAcc[k] = p2PreyAcc[k-1] | rotDown(strobes.p2Ring, k);
  end

  assign p1Wins = strobes.bothLegal & (|(p1PreyAcc[REACH] & strobes.p2Ring));
  assign p2Wins = strobes.bothLegal & (|(p2PreyAcc[REACH] & strobes.p1Ring));
  assign tied   = strobes.bothLegal & (|(strobes.p1Ring & strobes.p2Ring));

endmodule

// File: rtl/handGameJudge.sv
module handGameJudge
  import handGamePkg::*;
(
  input  logic [2:0] player1Move,
  input  logic [2:0] player2Move,
  output logic       p1Wins,
  output logic       p2Wins,
  output logic       tied
);

  judgeStrobes_t strobes;

  moveDecode u_decode (
    .p1Code  (player1Move),
    .p2Code  (player2Move),
    .strobes (strobes)
  );

  outcomeDatapath u_outcome (
    .strobes (strobes),
    .p1Wins  (p1Wins),
    .p2Wins  (p2Wins),
    .tied    (tied)
  );

endmodule

// File: rtl/handGameJudgeChecker.sv
module handGameJudgeChecker (
  input logic [2:0] p1Code,
  input logic [2:0] p2Code,
  input logic       p1Wins,
  input logic       p2Wins,
  input logic       tied
);

  logic legal1;
  logic legal2;
  assign legal1 = (p1Code <= 3'd4);
  assign legal2 = (p2Code <= 3'd4);

  always_comb begin
    // R7
    valid_single_outcome_chk: assert (!(legal1 && legal2) || $onehot({p1Wins, p2Wins, tied}));
    // R6
    illegal_all_low_chk: assert ((legal1 && legal2) || ({p1Wins, p2Wins, tied} == 3'b000));
    // R5
    same_move_tied_chk: assert (!(legal1 && p1Code == p2Code) || (tied && !p1Wins && !p2Wins));
    // R3
    no_double_win_chk: assert (!(p1Wins && p2Wins));
    // R2
    rock_beats_scissors_chk: assert (!(p1Code == 3'b000 && p2Code == 3'b010) || p1Wins);
    // R4
    spock_loses_to_lizard_chk: assert (!(p1Code == 3'b100 && p2Code == 3'b011) || p2Wins);
  end

endmodule

bind handGameJudge handGameJudgeChecker chk (
  .p1Code (player1Move),
  .p2Code (player2Move),
  .p1Wins (p1Wins),
  .p2Wins (p2Wins),
  .tied   (tied)
);

// File: tb/handGameJudge_test.sv
module handGameJudge_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic [2:0] player1Move = 3'b000;
  logic [2:0] player2Move = 3'b000;
  logic p1Wins, p2Wins, tied;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  handGameJudge uut (
    .player1Move (player1Move),
    .player2Move (player2Move),
    .p1Wins      (p1Wins),
    .p2Wins      (p2Wins),
    .tied        (tied)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount >= WATCHDOG_CYCLES) begin
      failures = failures + 1;
      $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG_CYCLES);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  // Reference per R1/R2: 0 Rock, 1 Paper, 2 Scissors, 3 Lizard, 4 Spock.
  function automatic bit refBeats(input logic [2:0] a, input logic [2:0] b);
    case (a)
      3'd0: return (b == 3'd2) || (b == 3'd3);
      3'd1: return (b == 3'd0) || (b == 3'd4);
      3'd2: return (b == 3'd1) || (b == 3'd3);
      3'd3: return (b == 3'd1) || (b == 3'd4);
      3'd4: return (b == 3'd0) || (b == 3'd2);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] refOutcome(input logic [2:0] a, input logic [2:0] b);
    if (a > 3'd4 || b > 3'd4) return 3'b000;
    if (a == b) return 3'b001;
    if (refBeats(a, b)) return 3'b100;
    return 3'b010;
  endfunction

  task automatic applyPair(input logic [2:0] a, input logic [2:0] b);
    @(posedge clk);
    #1;
    player1Move = a;
    player2Move = b;
    @(negedge clk);
  endtask

  task automatic expectFlags(input string req, input logic [2:0] expFlags);
    checks = checks + 1;
    if ({p1Wins, p2Wins, tied} !== expFlags) begin
      failures = failures + 1;
      $display("FAIL %s: p1=%0d p2=%0d actual {p1Wins,p2Wins,tied}=%b expected %b",
               req, player1Move, player2Move, {p1Wins, p2Wins, tied}, expFlags);
    end
  endtask

  task automatic runStartState();
    @(negedge clk);
    expectFlags("R5 initial rock-rock", 3'b001);
  endtask

  task automatic runTieScenario();
    for (int m = 0; m < 5; m++) begin
      applyPair(3'(m), 3'(m));
      expectFlags("R5", 3'b001);
    end
  endtask

  task automatic runWinTableScenario();
    logic [2:0] winners [10] = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd4};
    logic [2:0] losers  [10] = '{3'd2, 3'd3, 3'd0, 3'd4, 3'd1, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2};
    for (int i = 0; i < 10; i++) begin
      applyPair(winners[i], losers[i]);
      expectFlags("R2 R3 player one wins", 3'b100);
      applyPair(losers[i], winners[i]);
      expectFlags("R2 R4 player two wins", 3'b010);
    end
  endtask

  task automatic runInvalidScenario();
    for (int bad = 5; bad < 8; bad++) begin
      for (int other = 0; other < 8; other++) begin
        applyPair(3'(bad), 3'(other));
        expectFlags("R6 illegal player one", 3'b000);
        applyPair(3'(other), 3'(bad));
        expectFlags("R6 illegal player two", 3'b000);
      end
    end
  endtask

  task automatic runExhaustiveSweep();
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        applyPair(3'(a), 3'(b));
        expectFlags("R1 sweep", refOutcome(3'(a), 3'(b)));
        if (a < 5 && b < 5) begin
          checks = checks + 1;
          if ($countones({p1Wins, p2Wins, tied}) != 1) begin
            failures = failures + 1;
            $display("FAIL R7: p1=%0d p2=%0d actual flags=%b expected exactly one set",
                     a, b, {p1Wins, p2Wins, tied});
          end
        end
      end
    end
  endtask

  initial begin
    runStartState();
    runTieScenario();
    runWinTableScenario();
    runInvalidScenario();
    runExhaustiveSweep();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule